// File: doc/BRIEF.md
# Oscillator Frequency Window Checker

This block watches the recovered-clock oscillator of a clock-and-data recovery loop and decides, once per fixed measurement gate, whether the oscillator runs too slow, too fast or inside an allowed band. The gate is a fixed number of reference-clock cycles. During each gate the block counts oscillator edges after a fixed prescale. When the gate closes, the count is tested against an inclusive lower and upper bound.

An out-of-band result produces a single-cycle correction pulse. A slow oscillator gives a raise pulse and a fast one gives a lower pulse. These pulses go to the loop's frequency path. The block also drives a mute select for the 2:1 mux in front of the phase detector's up/down signals. The phase path is muted from reset until the first in-band result. It stays muted whenever the latest result is out of band. The oscillator count crosses into the reference domain as a Gray code, and every decision is made in the reference domain.

Top module: `fwd_window_detector`

## Requirements
- R1: While `rst` is high, at each reference edge `up_pulse` and `dn_pulse` are 0, `in_window` is 0 and `pd_mute` is 1.
- R2: Gates are back to back, each exactly `GATE_CYC` reference cycles long. The k-th gate (k = 1, 2, ...) closes on the k*`GATE_CYC`-th rising `ref_clk` edge after `rst` falls. The outputs change right after that edge, so with a persistent out-of-band oscillator successive pulses are exactly `GATE_CYC` cycles apart.
- R3: The first gate after reset only sets up the measurement baseline. When it closes, no pulse is issued and `in_window` stays 0.
- R4: The measured value is the number of prescaled oscillator edges (one per `PRESCALE` `osc_clk` rising edges) during the gate. If it is below `LOW_BOUND`, a one-cycle `up_pulse` is issued when the gate closes.
- R5: If the measured value is above `HIGH_BOUND`, a one-cycle `dn_pulse` is issued when the gate closes.
- R6: If `LOW_BOUND` <= value <= `HIGH_BOUND` (both bounds included), no pulse is issued and `in_window` becomes 1.
- R7: `up_pulse` and `dn_pulse` are never high together. Each is high for exactly one reference cycle, and only in the cycle right after a gate closes.
- R8: `in_window` changes only right after a gate closes and holds its value for the rest of the gate.
- R9: `pd_mute` is always the inverse of `in_window`: 1 (phase path muted) after any out-of-band result, 0 only after an in-band result.
- R10: A stopped oscillator measures 0 and gives an `up_pulse` at every gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; sets the gate and all outputs |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| osc_clk | input | 1 | Oscillator clock under test |
| up_pulse | output | 1 | One-cycle raise-frequency pulse |
| dn_pulse | output | 1 | One-cycle lower-frequency pulse |
| in_window | output | 1 | Latest completed measurement was inside the band |
| pd_mute | output | 1 | 1 = phase-detector path muted, frequency path in control |

## Verification
The oscillator period is set so that a gate holds exactly 40, 50, 64, 80 or 100 prescaled edges, and it is also stopped. With bounds 50 and 80, these cases separate below-band, both inclusive edges, mid-band and above-band results from a dead oscillator. After each period change, the first gate mixes two frequencies, so the bench ignores it. Every gate after that is checked exactly, and so is every cycle between gate ends. Runs of repeated raise pulses confirm the gate spacing, and the first gate after reset must produce nothing.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        VERDICT_OK   = 2'd0,
        VERDICT_SLOW = 2'd1,
        VERDICT_FAST = 2'd2
    } verdict_e;

    typedef struct packed {
        logic raise;
        logic lower;
        logic inband;
        logic mute;
    } fwd_result_t;

    function automatic verdict_e classify(input int unsigned value,
                                          input int unsigned lo,
                                          input int unsigned hi);
        if (value < lo)      return VERDICT_SLOW;
        else if (value > hi) return VERDICT_FAST;
        else                 return VERDICT_OK;
    endfunction

endpackage

// File: rtl/fwd_gate_timer.sv
module fwd_gate_timer #(
    parameter int GATE_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int TW = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(GATE_CYC - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/fwd_osc_counter.sv
module fwd_osc_counter #(
    parameter int PRESCALE = 4,
    parameter int CW       = 9
) (
    input  logic          osc_clk,
    input  logic          rst,
    output logic [CW-1:0] gray_o
);
    logic rst_m1, rst_osc;
    logic edge_en;
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    always_ff @(posedge osc_clk) begin
        rst_m1  <= rst;
        rst_osc <= rst_m1;
    end

    generate
        if (PRESCALE > 1) begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge osc_clk) begin
                if (rst_osc || pre_q == PLAST) pre_q <= '0;
                else                           pre_q <= pre_q + 1'b1;
            end
            assign edge_en = (pre_q == PLAST);
        end else begin : g_nodiv
            assign edge_en = 1'b1;
        end
    endgenerate

    assign bin_nx = bin_q + 1'b1;

    always_ff @(posedge osc_clk) begin
        if (rst_osc) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else if (edge_en) begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/fwd_gray_sync.sv
module fwd_gray_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] gray_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= gray_i;
                else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign gray_o = stage_q[STAGES-1];
endmodule

// File: rtl/fwd_window_compare.sv
module fwd_window_compare
    import fwd_pkg::*;
#(
    parameter int CW         = 9,
    parameter int LOW_BOUND  = 50,
    parameter int HIGH_BOUND = 80
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [CW-1:0] gray_i,
    output fwd_result_t   res_o
);
    logic [CW-1:0] cur_bin;
    logic [CW-1:0] prev_q;
    logic [CW-1:0] delta;
    logic          primed_q;
    verdict_e      verdict;

    always_comb begin
        cur_bin[CW-1] = gray_i[CW-1];
        for (int i = CW - 2; i >= 0; i--)
            cur_bin[i] = cur_bin[i+1] ^ gray_i[i];
    end

    assign delta   = cur_bin - prev_q;
    assign verdict = classify(int'(delta), LOW_BOUND, HIGH_BOUND);

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q     <= 1'b0;
            prev_q       <= '0;
            res_o.raise  <= 1'b0;
            res_o.lower  <= 1'b0;
            res_o.inband <= 1'b0;
            res_o.mute   <= 1'b1;
        end else begin
            res_o.raise <= 1'b0;
            res_o.lower <= 1'b0;
            if (tick_i) begin
                prev_q <= cur_bin;
                if (!primed_q) begin
                    primed_q <= 1'b1;
                end else begin
                    res_o.raise  <= (verdict == VERDICT_SLOW);
                    res_o.lower  <= (verdict == VERDICT_FAST);
                    res_o.inband <= (verdict == VERDICT_OK);
                    res_o.mute   <= (verdict != VERDICT_OK);
                end
            end
        end
    end
endmodule

// File: rtl/fwd_window_detector.sv
module fwd_window_detector
    import fwd_pkg::*;
#(
    parameter int GATE_CYC   = 64,
    parameter int PRESCALE   = 4,
    parameter int LOW_BOUND  = 50,
    parameter int HIGH_BOUND = 80,
    parameter int SYNC_STG   = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic osc_clk,
    output logic up_pulse,
    output logic dn_pulse,
    output logic in_window,
    output logic pd_mute
);
    localparam int CW = $clog2(2 * HIGH_BOUND + 2) + 1;

    logic          gate_tick;
    logic [CW-1:0] gray_osc;
    logic [CW-1:0] gray_ref;
    fwd_result_t   result;

    fwd_gate_timer #(.GATE_CYC(GATE_CYC)) u_gate (
        .clk    (ref_clk),
        .rst    (rst),
        .tick_o (gate_tick)
    );

    fwd_osc_counter #(.PRESCALE(PRESCALE), .CW(CW)) u_osc (
        .osc_clk (osc_clk),
        .rst     (rst),
        .gray_o  (gray_osc)
    );

    fwd_gray_sync #(.W(CW), .STAGES(SYNC_STG)) u_sync (
        .clk    (ref_clk),
        .rst    (rst),
        .gray_i (gray_osc),
        .gray_o (gray_ref)
    );

    fwd_window_compare #(
        .CW(CW), .LOW_BOUND(LOW_BOUND), .HIGH_BOUND(HIGH_BOUND)
    ) u_cmp (
        .clk    (ref_clk),
        .rst    (rst),
        .tick_i (gate_tick),
        .gray_i (gray_ref),
        .res_o  (result)
    );

    assign up_pulse  = result.raise;
    assign dn_pulse  = result.lower;
    assign in_window = result.inband;
    assign pd_mute   = result.mute;
endmodule

// File: rtl/fwd_window_detector_chk.sv
module fwd_window_detector_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic up,
    input logic dn,
    input logic win,
    input logic mute
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!up && !dn && !win && mute)); // R1
    AST_PULSE_AFTER_GATE: assert property (@(posedge clk) disable iff (rst) (up || dn) |-> $past(tick)); // R2
    AST_NO_BOTH_PULSES: assert property (@(posedge clk) disable iff (rst) !(up && dn)); // R7
    AST_UP_SINGLE: assert property (@(posedge clk) disable iff (rst) up |=> !up); // R7
    AST_DN_SINGLE: assert property (@(posedge clk) disable iff (rst) dn |=> !dn); // R7
    AST_WIN_HELD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(win)); // R8
    AST_MUTE_INVERSE: assert property (@(posedge clk) disable iff (rst) mute != win); // R9
endmodule

bind fwd_window_detector fwd_window_detector_chk chk_i (
    .clk  (ref_clk),
    .rst  (rst),
    .tick (gate_tick),
    .up   (up_pulse),
    .dn   (dn_pulse),
    .win  (in_window),
    .mute (pd_mute)
);

// File: tb/fwd_window_detector_tb_top.sv
`timescale 1ps/1ps
module fwd_window_detector_tb_top;
    localparam int N      = 64;
    localparam int X      = 4;
    localparam int LO     = 50;
    localparam int HI     = 80;
    localparam int REF_PS = 10000;

    logic ref_clk = 1'b0;
    logic osc_clk = 1'b0;
    logic rst     = 1'b1;
    logic up_pulse, dn_pulse, in_window, pd_mute;

    int checks = 0;
    int errors = 0;
    int osc_per = 2500;
    int k = -1;
    int gates_done = 0;
    int dirty_gate = 0;
    bit known = 1'b1;
    int exp_win = 0;
    int last_up_k = -1;
    int last_up_g = -1;
    bit finished = 1'b0;

    fwd_window_detector #(
        .GATE_CYC(N), .PRESCALE(X), .LOW_BOUND(LO), .HIGH_BOUND(HI)
    ) dut_i (
        .ref_clk   (ref_clk),
        .rst       (rst),
        .osc_clk   (osc_clk),
        .up_pulse  (up_pulse),
        .dn_pulse  (dn_pulse),
        .in_window (in_window),
        .pd_mute   (pd_mute)
    );

    always #(REF_PS/2) ref_clk = ~ref_clk;

    initial forever begin
        if (osc_per == 0) begin
            osc_clk = 1'b0;
            @(osc_per);
        end else begin
            #(osc_per/2) osc_clk = ~osc_clk;
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at edge %0d", req, what, act, exp, k);
        end
    endtask

    // Reference model, evaluated on every falling edge
    always @(negedge ref_clk) begin
        if (rst) begin
            chk(up_pulse, 0, "R1", "up in reset");
            chk(dn_pulse, 0, "R1", "dn in reset");
            chk(in_window, 0, "R1", "win in reset");
            chk(pd_mute, 1, "R1", "mute in reset");
        end else begin
            k++;
            if ((k + 1) % N == 0) begin
                int g;
                g = (k + 1) / N;
                gates_done = g;
                if (g == 1) begin
                    chk(up_pulse, 0, "R3", "warm-up up");
                    chk(dn_pulse, 0, "R3", "warm-up dn");
                    chk(in_window, 0, "R3", "warm-up win");
                end else if (g == dirty_gate) begin
                    known = 1'b0;
                end else begin
                    int cnt;
                    bit slow, fast;
                    string lbl;
                    cnt  = (osc_per == 0) ? 0 : (N * REF_PS) / (X * osc_per);
                    slow = (cnt < LO);
                    fast = (cnt > HI);
                    lbl  = (osc_per == 0) ? "R10" : slow ? "R4" : fast ? "R5" : "R6";
                    chk(up_pulse, slow, lbl, "up at gate end");
                    chk(dn_pulse, fast, lbl, "dn at gate end");
                    chk(in_window, !(slow || fast), lbl, "win at gate end");
                    chk(pd_mute, slow || fast, "R9", "mute at gate end");
                    if (slow && up_pulse) begin
                        if (last_up_g == g - 1)
                            chk(k - last_up_k, N, "R2", "pulse spacing");
                        last_up_k = k;
                        last_up_g = g;
                    end
                    known   = 1'b1;
                    exp_win = !(slow || fast);
                end
            end else begin
                chk(up_pulse, 0, "R7", "up between gates");
                chk(dn_pulse, 0, "R7", "dn between gates");
                if (known) begin
                    chk(in_window, exp_win, "R8", "win held");
                    chk(pd_mute, !exp_win, "R9", "mute held");
                end
            end
        end
    end

    task automatic wait_gates(input int n);
        int target;
        target = gates_done + n;
        while (gates_done < target) begin
            @(negedge ref_clk);
            #1;
        end
    endtask

    task automatic set_osc(input int per);
        #299;
        dirty_gate = gates_done + 1;
        osc_per = per;
    endtask

    initial begin
        repeat (5) @(negedge ref_clk);
        #1 rst = 1'b0;
        wait_gates(4);  set_osc(4000);   // 40 edges: below band
        wait_gates(4);  set_osc(3200);   // 50 edges: lower bound
        wait_gates(3);  set_osc(2000);   // 80 edges: upper bound
        wait_gates(3);  set_osc(1600);   // 100 edges: above band
        wait_gates(4);  set_osc(0);      // stopped oscillator
        wait_gates(4);  set_osc(2500);   // 64 edges: back in band
        wait_gates(3);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(REF_PS * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule